// File: doc/BRIEF.md
# Non-Secure Privilege Window and Access-Permission Combiner

This block is the register window that non-secure software can reach in a peripheral protection scheme. It holds one privilege attribute word for each of ten peripheral protection controllers: four AHB expansion controllers, two internal APB controllers and four APB expansion controllers. It turns those words into per-port signals for the fabric. For every port of every controller it drives a `nonsec` flag and an access-permission flag.

The security attribute word and the secure-side privilege word of each controller come from a separate secure bank on input buses. The permission flag of a port takes the locally stored non-secure privilege bit when that port is marked non-secure. Otherwise it takes the secure privilege bit.

The window is a 4 KB space on a simple request bus. Reads complete one cycle after the request. A read at the top of the window returns a fixed set of identification bytes.

Top module: `nsp_window`

## Requirements
- R1: After a synchronous active-low reset, every stored privilege word is zero, `bus_rvalid` is 0 and `bus_rdata` is zero.
- R2: Controller slots are laid out as follows: slots 0–3 are AHB expansion 0–3, slots 4–5 are internal APB 0–1, and slots 6–9 are APB expansion 0–3. Port i of slot s sits at bit s*32+i of every flat bus. `port_nonsec` equals the `sec_ns_words` bit for ports below the slot's port count and is 0 above it.
- R3: For each port below the slot's port count, `port_ap` is the stored privilege bit when the `sec_ns_words` bit is 1, and the `sec_sp_words` bit otherwise. Ports at or above the count drive 0.
- R4: A full-word write (`bus_size`=2, `bus_addr[1:0]`=0) stores the data to the addressed slot, and a word read returns it. The privilege word addresses are: 0xA0+4k for AHB expansion k, 0xB0 and 0xB4 for internal APB 0 and 1, and 0xC0+4k for APB expansion k.
- R5: A stored word keeps only the bits below its slot's port count. Defaults: 16 ports for expansion slots, 4 for internal APB 0 and 1 for internal APB 1. The other bits read as 0.
- R6: Byte (`bus_size`=0) and halfword (`bus_size`=1) writes change no stored word and no output.
- R7: A byte read returns the word shifted right by 8×`bus_addr[1:0]` and masked to 8 bits. A halfword read does the same with a 16-bit mask.
- R8: Offset 0x90, and any unmapped offset such as 0xB8, reads as zero and ignores writes.
- R9: The word at 0xFD0+4n reads byte n of the list 04,00,00,00,53,B8,0B,00,0D,F0,05,B1 (n = 0..11). Writes there are ignored.
- R10: Read data and `bus_rvalid`=1 appear in the cycle after the request. With no read request, the next cycle has `bus_rvalid`=0 and `bus_rdata`=0.
- R11: `port_ap` reflects a written privilege word from the clock edge that stores it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| sec_ns_words | input | 320 | Security attribute words from the secure bank, 32 bits per slot |
| sec_sp_words | input | 320 | Secure privilege words from the secure bank, 32 bits per slot |
| port_nonsec | output | 320 | Per-port non-secure flag |
| port_ap | output | 320 | Per-port access permission |

## Verification
The assertions assume that `rst_n` is held low through the first clock edge. They also assume that the bus fields are stable and known whenever `bus_sel` is high, and that the secure-bank buses change only between clock edges. The bench drives every input from the falling edge, starts in reset, and changes the secure words only while no request is in flight. As a result, the property that stable inputs give stable permissions is never tripped by a mid-cycle change.

// File: rtl/nsp_pkg.sv
// Package: shared sizes and helpers for the non-secure privilege window.
// Assumes every controller has at most SLOT_W ports.
package nsp_pkg;
    localparam int SLOT_W    = 32;
    localparam int NUM_AHBX  = 4;
    localparam int NUM_APBI  = 2;
    localparam int NUM_APBX  = 4;
    localparam int NUM_SLOT  = NUM_AHBX + NUM_APBI + NUM_APBX;
    localparam int SLOT_IW   = $clog2(NUM_SLOT);
    localparam int FLAT_W    = NUM_SLOT * SLOT_W;
    localparam int BASE_APBI = NUM_AHBX;
    localparam int BASE_APBX = NUM_AHBX + NUM_APBI;

    // Port count of a slot, given the four configured counts.
    function automatic int slot_ports(input int s, input int ahbx, input int apb0,
                                      input int apb1, input int apbx);
        if (s < BASE_APBI)      return ahbx;
        else if (s == BASE_APBI) return apb0;
        else if (s < BASE_APBX) return apb1;
        else                    return apbx;
    endfunction

    // Mask with the low n bits set.
    function automatic logic [SLOT_W-1:0] port_mask(input int n);
        logic [SLOT_W-1:0] m;
        m = '0;
        for (int i = 0; i < SLOT_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Identification byte n of the window.
    function automatic logic [7:0] id_byte(input logic [3:0] n);
        case (n)
            4'd0:  return 8'h04;
            4'd4:  return 8'h53;
            4'd5:  return 8'hB8;
            4'd6:  return 8'h0B;
            4'd8:  return 8'h0D;
            4'd9:  return 8'hF0;
            4'd10: return 8'h05;
            4'd11: return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/nsp_addr_decode.sv
// Address decoder: maps a window offset to a privilege slot or an ID byte.
// Assumes 12-bit byte offsets; writes must be word-sized and word-aligned.
module nsp_addr_decode
    import nsp_pkg::*;
(
    input  logic [11:0]        addr,
    input  logic [1:0]         size,
    output logic               slot_hit,
    output logic [SLOT_IW-1:0] slot_idx,
    output logic               id_hit,
    output logic [3:0]         id_idx,
    output logic               word_ok
);
    // Slot decode: bits [3:2] pick the instance inside each 16-byte group.
    always_comb begin
        slot_hit = 1'b0;
        slot_idx = '0;
        case (addr[11:4])
            8'h0A: begin
                slot_hit = 1'b1;
                slot_idx = SLOT_IW'(addr[3:2]);
            end
            8'h0B: begin
                slot_hit = ~addr[3];
                slot_idx = SLOT_IW'(BASE_APBI) + SLOT_IW'(addr[2]);
            end
            8'h0C: begin
                slot_hit = 1'b1;
                slot_idx = SLOT_IW'(BASE_APBX) + SLOT_IW'(addr[3:2]);
            end
            default: ;
        endcase
    end

    // ID decode: words 0xFD0..0xFFC map to bytes 0..11.
    always_comb begin
        id_hit = (addr[11:4] >= 8'hFD);
        id_idx = addr[5:2] - 4'd4;
    end

    // Only aligned full-word accesses may store.
    always_comb word_ok = (size == 2'd2) && (addr[1:0] == 2'b00);
endmodule

// File: rtl/nsp_word_bank.sv
// Storage for the per-slot non-secure privilege words, each masked to its
// slot's port count. Assumes wr_en is asserted only for an addressed slot.
module nsp_word_bank
    import nsp_pkg::*;
#(
    parameter int AHBX_PORTS = 16,
    parameter int APB0_PORTS = 4,
    parameter int APB1_PORTS = 1,
    parameter int APBX_PORTS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_IW-1:0] wr_slot,
    input  logic [SLOT_W-1:0]  wr_data,
    output logic [FLAT_W-1:0]  nsp_flat
);
    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        localparam int NP = slot_ports(g, AHBX_PORTS, APB0_PORTS, APB1_PORTS, APBX_PORTS);
        localparam logic [SLOT_W-1:0] MASK = port_mask(NP);
        logic [SLOT_W-1:0] word;

        // Hold the masked word; load on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word <= '0;
            else if (wr_en && (wr_slot == SLOT_IW'(g)))
                word <= wr_data & MASK;
        end

        assign nsp_flat[g*SLOT_W +: SLOT_W] = word;

        // R5
        wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_slot == SLOT_IW'(g))) |=> (word == ($past(wr_data) & MASK)));
    end
endmodule

// File: rtl/nsp_perm_combine.sv
// Per-port combiner: nonsec follows the security bit, and the permission
// picks the non-secure or secure privilege bit. Unused ports drive 0.
module nsp_perm_combine
    import nsp_pkg::*;
#(
    parameter int AHBX_PORTS = 16,
    parameter int APB0_PORTS = 4,
    parameter int APB1_PORTS = 1,
    parameter int APBX_PORTS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAT_W-1:0] ns_flat,
    input  logic [FLAT_W-1:0] sp_flat,
    input  logic [FLAT_W-1:0] nsp_flat,
    output logic [FLAT_W-1:0] nonsec_flat,
    output logic [FLAT_W-1:0] ap_flat
);
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        localparam int NP = slot_ports(s, AHBX_PORTS, APB0_PORTS, APB1_PORTS, APBX_PORTS);
        for (genvar p = 0; p < SLOT_W; p++) begin : g_port
            localparam int B = s*SLOT_W + p;
            if (p < NP) begin : g_live
                // Select the privilege source by the port's security bit.
                assign nonsec_flat[B] = ns_flat[B];
                assign ap_flat[B]     = ns_flat[B] ? nsp_flat[B] : sp_flat[B];
            end else begin : g_dead
                assign nonsec_flat[B] = 1'b0;
                assign ap_flat[B]     = 1'b0;
            end
        end
    end

    // R3
    ap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(ns_flat) && $stable(sp_flat) && $stable(nsp_flat)) |-> $stable(ap_flat));
endmodule

// File: rtl/nsp_window.sv
// Top of the non-secure privilege window: decodes bus requests, stores
// privilege words, returns read data one cycle later and drives the
// per-port nonsec and permission outputs. Assumes bus fields are valid
// whenever bus_sel is high.
module nsp_window
    import nsp_pkg::*;
#(
    parameter int AHBX_PORTS = 16,
    parameter int APB0_PORTS = 4,
    parameter int APB1_PORTS = 1,
    parameter int APBX_PORTS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [FLAT_W-1:0] sec_ns_words,
    input  logic [FLAT_W-1:0] sec_sp_words,
    output logic [FLAT_W-1:0] port_nonsec,
    output logic [FLAT_W-1:0] port_ap
);
    logic               slot_hit;
    logic [SLOT_IW-1:0] slot_idx;
    logic               id_hit;
    logic [3:0]         id_idx;
    logic               word_ok;
    logic               wr_en;
    logic [FLAT_W-1:0]  nsp_flat;
    logic [31:0]        word_val;
    logic [31:0]        lane_val;

    nsp_addr_decode u_dec (
        .addr     (bus_addr),
        .size     (bus_size),
        .slot_hit (slot_hit),
        .slot_idx (slot_idx),
        .id_hit   (id_hit),
        .id_idx   (id_idx),
        .word_ok  (word_ok)
    );

    // Store only aligned word writes that land on a privilege slot.
    always_comb wr_en = bus_sel && bus_wr && word_ok && slot_hit;

    nsp_word_bank #(
        .AHBX_PORTS (AHBX_PORTS),
        .APB0_PORTS (APB0_PORTS),
        .APB1_PORTS (APB1_PORTS),
        .APBX_PORTS (APBX_PORTS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (slot_idx),
        .wr_data  (bus_wdata),
        .nsp_flat (nsp_flat)
    );

    nsp_perm_combine #(
        .AHBX_PORTS (AHBX_PORTS),
        .APB0_PORTS (APB0_PORTS),
        .APB1_PORTS (APB1_PORTS),
        .APBX_PORTS (APBX_PORTS)
    ) u_comb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ns_flat     (sec_ns_words),
        .sp_flat     (sec_sp_words),
        .nsp_flat    (nsp_flat),
        .nonsec_flat (port_nonsec),
        .ap_flat     (port_ap)
    );

    // Word-level read value: a slot word, an ID byte, or zero.
    always_comb begin
        if (slot_hit)
            word_val = nsp_flat[int'(slot_idx)*SLOT_W +: SLOT_W];
        else if (id_hit)
            word_val = {24'h0, id_byte(id_idx)};
        else
            word_val = '0;
    end

    // Byte-lane extraction for sub-word reads.
    always_comb begin
        case (bus_size)
            2'd0:    lane_val = (word_val >> {bus_addr[1:0], 3'b000}) & 32'h0000_00FF;
            2'd1:    lane_val = (word_val >> {bus_addr[1:0], 3'b000}) & 32'h0000_FFFF;
            default: lane_val = word_val;
        endcase
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else if (bus_sel && !bus_wr) begin
            bus_rdata  <= lane_val;
            bus_rvalid <= 1'b1;
        end else begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end
    end

    // R10
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    // R10
    idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (!bus_rvalid && (bus_rdata == 32'h0)));

    // R6
    sub_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_size != 2'd2)) |=> $stable(nsp_flat));

    // R8
    zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == 12'h090) && (bus_size == 2'd2)) |=> (bus_rdata == 32'h0));

    // R9
    id_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == 12'hFE0) && (bus_size == 2'd2)) |=> (bus_rdata == 32'h53));
endmodule

// File: tb/nsp_window_bench.sv
module nsp_window_bench;
    localparam int NS = 10;
    localparam int SW = 32;
    localparam int FW = NS*SW;
    localparam int PORTS [0:NS-1] = '{16, 16, 16, 16, 4, 1, 16, 16, 16, 16};
    localparam logic [11:0] SLOT_ADDR [0:NS-1] =
        '{12'h0A0, 12'h0A4, 12'h0A8, 12'h0AC, 12'h0B0, 12'h0B4, 12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC};

    // Table: write address, write data, expected word read-back, slot (15 = none)
    localparam int NV = 12;
    localparam logic [11:0] T_ADDR [0:NV-1] =
        '{12'h0A0, 12'h0AC, 12'h0B0, 12'h0B4, 12'h0C0, 12'h0CC,
          12'h0B8, 12'h090, 12'hFE0, 12'hFD0, 12'hFFC, 12'hFE4};
    localparam logic [31:0] T_WDATA [0:NV-1] =
        '{32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_A5A5, 32'h0001_8001,
          32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    localparam logic [31:0] T_EXP [0:NV-1] =
        '{32'h0000_FFFF, 32'h0000_5678, 32'h0000_000F, 32'h0000_0001, 32'h0000_A5A5, 32'h0000_8001,
          32'h0, 32'h0, 32'h53, 32'h04, 32'hB1, 32'hB8};
    localparam logic [3:0] T_SLOT [0:NV-1] =
        '{4'd0, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd15, 4'd15, 4'd15, 4'd15, 4'd15, 4'd15};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [FW-1:0] ns_in = '0;
    logic [FW-1:0] sp_in = '0;
    logic [FW-1:0] port_nonsec;
    logic [FW-1:0] port_ap;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] model [0:NS-1];

    nsp_window u_nsp_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_size     (bus_size),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .sec_ns_words (ns_in),
        .sec_sp_words (sp_in),
        .port_nonsec  (port_nonsec),
        .port_ap      (port_ap)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [1:0] sz,
                           output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        d = bus_rdata; v = bus_rvalid;
        bus_sel = 1'b0;
    endtask

    // Expected outputs from the requirement formulas and the bench model.
    task automatic check_outputs(input string req);
        logic [FW-1:0] e_ns;
        logic [FW-1:0] e_ap;
        e_ns = '0; e_ap = '0;
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < SW; p++) begin
                if (p < PORTS[s]) begin
                    e_ns[s*SW+p] = ns_in[s*SW+p];
                    e_ap[s*SW+p] = ns_in[s*SW+p] ? model[s][p] : sp_in[s*SW+p];
                end
            end
        end
        check({req, " nonsec"}, port_nonsec, e_ns);
        check({req, " ap"}, port_ap, e_ap);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v;
        for (int s = 0; s < NS; s++) model[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10: reset state and idle response
        check("R1 rvalid", FW'(bus_rvalid), FW'(1'b0));
        check("R10 idle rdata", FW'(bus_rdata), FW'(0));
        for (int s = 0; s < NS; s++) begin
            do_read(SLOT_ADDR[s], 2'd2, d, v);
            check("R1 reset word", FW'(d), FW'(0));
        end
        sp_in = '1; ns_in = '0;
        @(negedge clk);
        check_outputs("R1 R3 reset sp");
        ns_in = '1;
        @(negedge clk);
        check_outputs("R1 R2 reset ns");

        // R4 R5 R8 R9: table walk, write then word read-back
        for (int i = 0; i < NV; i++) begin
            do_write(T_ADDR[i], 2'd2, T_WDATA[i]);
            do_read(T_ADDR[i], 2'd2, d, v);
            check("R4 R5 R8 R9 readback", FW'(d), FW'(T_EXP[i]));
            check("R10 rvalid", FW'(v), FW'(1'b1));
            if (T_SLOT[i] != 4'd15) model[T_SLOT[i]] = T_EXP[i];
        end
        @(negedge clk);
        check("R10 idle after read", FW'({bus_rvalid, bus_rdata}), FW'(0));

        // R3: several input patterns against stored words
        ns_in = {NS{32'hAAAA_AAAA}}; sp_in = {NS{32'h0F0F_0F0F}};
        @(negedge clk);
        check_outputs("R3 pattern a");
        ns_in = {NS{32'h5555_5555}}; sp_in = {NS{32'hFFFF_0000}};
        @(negedge clk);
        check_outputs("R3 pattern b");
        ns_in = '1; sp_in = '0;
        @(negedge clk);
        check_outputs("R2 R3 pattern c");

        // R11: output follows a write at the storing edge
        do_write(12'h0C4, 2'd2, 32'h0000_FFFF);
        model[7] = 32'h0000_FFFF;
        check("R11 ap after write", FW'(port_ap[7*SW +: SW]), FW'(32'h0000_FFFF));

        // R6: sub-word writes change nothing
        do_write(12'h0C4, 2'd0, 32'h0);
        do_write(12'h0C4, 2'd1, 32'h0);
        check_outputs("R6 outputs unchanged");
        do_read(12'h0C4, 2'd2, d, v);
        check("R6 word unchanged", FW'(d), FW'(32'h0000_FFFF));

        // R8: writes to the zero word and unmapped offsets leave the slots alone
        do_write(12'h090, 2'd2, 32'hFFFF_FFFF);
        do_write(12'h0B8, 2'd2, 32'hFFFF_FFFF);
        check_outputs("R8 outputs unchanged");

        // R7: sub-word reads (slot 3 holds 0x5678)
        do_read(12'h0AC, 2'd0, d, v);
        check("R7 byte lane0", FW'(d), FW'(32'h78));
        do_read(12'h0AD, 2'd0, d, v);
        check("R7 byte lane1", FW'(d), FW'(32'h56));
        do_read(12'h0AC, 2'd1, d, v);
        check("R7 half lane0", FW'(d), FW'(32'h5678));
        do_read(12'h0AE, 2'd1, d, v);
        check("R7 half lane2", FW'(d), FW'(32'h0));
        do_read(12'hFE4, 2'd0, d, v);
        check("R7 R9 id byte", FW'(d), FW'(32'hB8));

        // R9: ID bytes are read-only
        do_write(12'hFE0, 2'd2, 32'h0);
        do_read(12'hFE0, 2'd2, d, v);
        check("R9 id read-only", FW'(d), FW'(32'h53));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule